// File: doc/BRIEF.md
# Hardwired Instruction-Cycle Sequencer

This block is the fixed-logic control section of a small accumulator machine, together with the registers it steers: the memory address latch, the memory data latch, the program counter, the instruction register and the accumulator R1. A two-bit subcycle code selects one of four phases: instruction fetch, indirect address resolution, operand execution and interrupt entry. A step counter marks the timing slots T1, T2, T3 and T4 inside each phase. For every combination of subcycle, step and opcode, a decoder produces one set of register-transfer enables and memory strobes. At the last step of a phase the step counter goes back to T1 and the subcycle code takes the phase that follows.

The memory is external. Its address comes straight from the address latch and its write data from the data latch. A read returns its word within the same step. The five operations are load, add, bitwise and, increment-and-skip-on-zero, and branch-with-saved-return. Each has its own fixed slot schedule. The interrupt path writes the return address to a fixed location and jumps to a fixed handler. Entering that path also clears the interrupt enable.

Top module: `hw_cycle_ctrl`

## Requirements
- R1: While reset is held, `cyc_o` is 00, `step_o` is 0 (T1), `pc_o` is RESET_PC (0x010), `r1_o` is 0, and neither memory strobe is active.
- R2: Subcycle codes are 00 fetch, 01 indirect, 10 execute and 11 interrupt. `step_o` counts 0 for T1, 1 for T2 and so on. Every phase ends by returning `step_o` to 0 while `cyc_o` takes the next code.
- R3: Fetch takes three steps. T1 latches the address from PC. T2 reads memory into the data latch and increments PC. T3 copies the data latch into the instruction register.
- R4: An instruction word holds the opcode in bits 15:13, the indirect flag in bit 12 and the address in bits 11:0. After fetch, the next phase is indirect (01) when bit 12 is set and execute (10) when it is clear.
- R5: Indirect takes three steps. It reads the word at the instruction's address and replaces only the address bits 11:0 of the instruction register with bits 11:0 of that word. The opcode and the flag are left as they were.
- R6: Opcode 000 loads R1 with the operand word. Opcode 001 adds the operand to R1 modulo 2^16. Opcode 010 ANDs it into R1 bit by bit. Each takes three execute steps: address in T1, read in T2, R1 update in T3.
- R7: Opcode 011 reads the operand, increments it in T3 and writes it back to the same address in T4. In T4 it also increments PC one extra time when the incremented value is zero.
- R8: Opcode 100 writes the address of the following instruction to location X in T2 and sets PC to X. In T3 it increments PC, so execution continues at X+1.
- R9: Opcodes 101, 110 and 111 finish execute in a single step and change neither R1 nor memory.
- R10: If `irq` is high and the enable is set when execute ends, the interrupt phase follows. That phase stores the PC at SAVE_ADDR (0x000), sets PC to HANDLER_ADDR (0x001) and clears the enable. Otherwise fetch follows.
- R11: `mem_rd` and `mem_wr` are never active together, and `mem_rd` is active only in T2.
- R12: A one-cycle pulse on `int_en_set` sets the interrupt enable. While the enable is clear, a high `irq` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset, released synchronously inside |
| irq | input | 1 | interrupt request level |
| int_en_set | input | 1 | sets the interrupt enable |
| mem_addr | output | 12 | memory address (address latch) |
| mem_rd | output | 1 | memory read strobe |
| mem_wr | output | 1 | memory write strobe |
| mem_wdata | output | 16 | memory write data (data latch) |
| mem_rdata | input | 16 | memory read data, valid in the same step |
| pc_o | output | 12 | program counter |
| ir_o | output | 16 | instruction register |
| r1_o | output | 16 | accumulator R1 |
| cyc_o | output | 2 | current subcycle code |
| step_o | output | 2 | current timing step, 0 = T1 |

## Verification
The bench runs load, add and AND over every pairing of the operands 0x0000, 0xFFFF, 0x8001 and 0x5A3C. A sequencer with a broken carry or mask, or one that loads R1 in the wrong step, leaves a wrong accumulator value. The increment-and-skip operation is driven with 0xFFFF and 0xFFFE. A design that tests the zero condition before the increment, or skips on the wrong value, ends with PC off by one. An indirect instruction uses a pointer whose upper bits are set, so a design that overwrites the opcode during indirect runs the wrong operation. The interrupt is requested once with the enable clear and then again right after the handler is entered. A design that ignores the enable, or fails to clear it on entry, lands at the handler when it should not.

// File: rtl/hwcu_pkg.sv
package hwcu_pkg;

  typedef enum logic [1:0] {
    CYC_FETCH = 2'b00,
    CYC_IND   = 2'b01,
    CYC_EXE   = 2'b10,
    CYC_INT   = 2'b11
  } cyc_e;

  localparam logic [2:0] OPC_LDA = 3'd0;
  localparam logic [2:0] OPC_ADD = 3'd1;
  localparam logic [2:0] OPC_AND = 3'd2;
  localparam logic [2:0] OPC_ISZ = 3'd3;
  localparam logic [2:0] OPC_BSA = 3'd4;

  typedef enum logic [1:0] {MAR_HOLD, MAR_PC, MAR_IRA, MAR_SAVE} mar_src_e;
  typedef enum logic [1:0] {MBR_HOLD, MBR_MEM, MBR_PC, MBR_INC} mbr_src_e;
  typedef enum logic [1:0] {PC_HOLD, PC_INC, PC_IRA, PC_VEC} pc_src_e;
  typedef enum logic [1:0] {IR_HOLD, IR_ALL, IR_ADDR} ir_src_e;
  typedef enum logic [1:0] {R1_HOLD, R1_LOAD, R1_ADD, R1_AND} r1_src_e;

  typedef struct packed {
    mar_src_e mar;
    mbr_src_e mbr;
    pc_src_e  pc;
    ir_src_e  ir;
    r1_src_e  r1;
    logic     rd;
    logic     wr;
    logic     last;
    cyc_e     nxt;
    logic     int_entry;
  } ctl_t;

endpackage

// File: rtl/hwcu_timing.sv
module hwcu_timing
  import hwcu_pkg::*;
#(
  parameter int STEP_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              last,
  input  cyc_e              nxt,
  output cyc_e              cyc,
  output logic [STEP_W-1:0] step
);

  cyc_e              cyc_d;
  logic [STEP_W-1:0] step_d;

  always_comb begin
    if (last) begin
      cyc_d  = nxt;
      step_d = '0;
    end else begin
      cyc_d  = cyc;
      step_d = step + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc  <= CYC_FETCH;
      step <= '0;
    end else begin
      cyc  <= cyc_d;
      step <= step_d;
    end
  end

endmodule

// File: rtl/hwcu_decode.sv
module hwcu_decode
  import hwcu_pkg::*;
#(
  parameter int STEP_W = 2,
  parameter int OPW    = 3
) (
  input  cyc_e              cyc,
  input  logic [STEP_W-1:0] step,
  input  logic [OPW-1:0]    opcode,
  input  logic              word_ind,
  input  logic              mbr_zero,
  input  logic              irq_go,
  output ctl_t              ctl
);

  localparam int STEPS = 1 << STEP_W;

  logic done;
  cyc_e follow;

  always_comb begin
    ctl    = '0;
    done   = 1'b0;
    follow = CYC_FETCH;
    unique case (cyc)
      CYC_FETCH: begin
        case (int'(step))
          0: ctl.mar = MAR_PC;
          1: begin ctl.mbr = MBR_MEM; ctl.rd = 1'b1; ctl.pc = PC_INC; end
          2: begin
            ctl.ir = IR_ALL;
            done   = 1'b1;
            follow = word_ind ? CYC_IND : CYC_EXE;
          end
          default: done = 1'b1;
        endcase
      end
      CYC_IND: begin
        follow = CYC_EXE;
        case (int'(step))
          0: ctl.mar = MAR_IRA;
          1: begin ctl.mbr = MBR_MEM; ctl.rd = 1'b1; end
          default: begin ctl.ir = IR_ADDR; done = 1'b1; end
        endcase
      end
      CYC_EXE: begin
        follow = irq_go ? CYC_INT : CYC_FETCH;
        if (opcode == OPC_LDA || opcode == OPC_ADD ||
            opcode == OPC_AND || opcode == OPC_ISZ) begin
          case (int'(step))
            0: ctl.mar = MAR_IRA;
            1: begin ctl.mbr = MBR_MEM; ctl.rd = 1'b1; end
            2: begin
              if (opcode == OPC_ISZ) ctl.mbr = MBR_INC;
              else begin
                done = 1'b1;
                if (opcode == OPC_LDA)      ctl.r1 = R1_LOAD;
                else if (opcode == OPC_ADD) ctl.r1 = R1_ADD;
                else                        ctl.r1 = R1_AND;
              end
            end
            default: begin
              ctl.wr = 1'b1;
              ctl.pc = mbr_zero ? PC_INC : PC_HOLD;
              done   = 1'b1;
            end
          endcase
        end else if (opcode == OPC_BSA) begin
          case (int'(step))
            0: begin ctl.mar = MAR_IRA; ctl.mbr = MBR_PC; end
            1: begin ctl.pc = PC_IRA; ctl.wr = 1'b1; end
            default: begin ctl.pc = PC_INC; done = 1'b1; end
          endcase
        end else begin
          done = 1'b1;
        end
        ctl.int_entry = done && irq_go;
      end
      CYC_INT: begin
        case (int'(step))
          0: ctl.mbr = MBR_PC;
          1: begin ctl.mar = MAR_SAVE; ctl.pc = PC_VEC; end
          default: begin ctl.wr = 1'b1; done = 1'b1; end
        endcase
      end
      default: done = 1'b1;
    endcase
    if (int'(step) == STEPS - 1) done = 1'b1;
    ctl.last = done;
    ctl.nxt  = follow;
  end

endmodule

// File: rtl/hwcu_datapath.sv
module hwcu_datapath
  import hwcu_pkg::*;
#(
  parameter int             DW           = 16,
  parameter int             AW           = 12,
  parameter logic [AW-1:0]  RESET_PC     = 12'h010,
  parameter logic [AW-1:0]  SAVE_ADDR    = 12'h000,
  parameter logic [AW-1:0]  HANDLER_ADDR = 12'h001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctl_t          ctl,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mar,
  output logic [DW-1:0] mbr,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] ir,
  output logic [DW-1:0] r1
);

  localparam int PADW = DW - AW;

  logic          mar_en, mbr_en, pc_en, ir_en, r1_en;
  logic [AW-1:0] mar_d, pc_d;
  logic [DW-1:0] mbr_d, ir_d, r1_d;

  always_comb begin
    mar_en = (ctl.mar != MAR_HOLD);
    unique case (ctl.mar)
      MAR_PC:   mar_d = pc;
      MAR_IRA:  mar_d = ir[AW-1:0];
      MAR_SAVE: mar_d = SAVE_ADDR;
      default:  mar_d = mar;
    endcase

    mbr_en = (ctl.mbr != MBR_HOLD);
    unique case (ctl.mbr)
      MBR_MEM: mbr_d = mem_rdata;
      MBR_PC:  mbr_d = {{PADW{1'b0}}, pc};
      MBR_INC: mbr_d = mbr + 1'b1;
      default: mbr_d = mbr;
    endcase

    pc_en = (ctl.pc != PC_HOLD);
    unique case (ctl.pc)
      PC_INC:  pc_d = pc + 1'b1;
      PC_IRA:  pc_d = ir[AW-1:0];
      PC_VEC:  pc_d = HANDLER_ADDR;
      default: pc_d = pc;
    endcase

    ir_en = (ctl.ir != IR_HOLD);
    unique case (ctl.ir)
      IR_ALL:  ir_d = mbr;
      IR_ADDR: ir_d = {ir[DW-1:AW], mbr[AW-1:0]};
      default: ir_d = ir;
    endcase

    r1_en = (ctl.r1 != R1_HOLD);
    unique case (ctl.r1)
      R1_LOAD: r1_d = mbr;
      R1_ADD:  r1_d = r1 + mbr;
      R1_AND:  r1_d = r1 & mbr;
      default: r1_d = r1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mar <= '0;
      mbr <= '0;
      pc  <= RESET_PC;
      ir  <= '0;
      r1  <= '0;
    end else begin
      if (mar_en) mar <= mar_d;
      if (mbr_en) mbr <= mbr_d;
      if (pc_en)  pc  <= pc_d;
      if (ir_en)  ir  <= ir_d;
      if (r1_en)  r1  <= r1_d;
    end
  end

endmodule

// File: rtl/hw_cycle_ctrl.sv
module hw_cycle_ctrl
  import hwcu_pkg::*;
#(
  parameter int             DW           = 16,
  parameter int             AW           = 12,
  parameter int             OPW          = 3,
  parameter int             STEP_W       = 2,
  parameter logic [AW-1:0]  RESET_PC     = 12'h010,
  parameter logic [AW-1:0]  SAVE_ADDR    = 12'h000,
  parameter logic [AW-1:0]  HANDLER_ADDR = 12'h001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq,
  input  logic              int_en_set,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  output logic [AW-1:0]     pc_o,
  output logic [DW-1:0]     ir_o,
  output logic [DW-1:0]     r1_o,
  output logic [1:0]        cyc_o,
  output logic [STEP_W-1:0] step_o
);

  localparam int IND_BIT = AW;
  localparam int OP_LSB  = DW - OPW;

  logic              rst_s1, rst_q_n;
  logic              ien, ien_d;
  ctl_t              ctl;
  cyc_e              cyc;
  logic [STEP_W-1:0] step;
  logic [AW-1:0]     mar, pc;
  logic [DW-1:0]     mbr, ir, r1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      rst_s1  <= 1'b1;
      rst_q_n <= rst_s1;
    end
  end

  always_comb begin
    ien_d = ien;
    if (ctl.int_entry) ien_d = 1'b0;
    else if (int_en_set) ien_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) ien <= 1'b0;
    else          ien <= ien_d;
  end

  hwcu_timing #(.STEP_W(STEP_W)) u_timing (
    .clk   (clk),
    .rst_n (rst_q_n),
    .last  (ctl.last),
    .nxt   (ctl.nxt),
    .cyc   (cyc),
    .step  (step)
  );

  hwcu_decode #(.STEP_W(STEP_W), .OPW(OPW)) u_decode (
    .cyc      (cyc),
    .step     (step),
    .opcode   (ir[DW-1:OP_LSB]),
    .word_ind (mbr[IND_BIT]),
    .mbr_zero (mbr == '0),
    .irq_go   (irq && ien),
    .ctl      (ctl)
  );

  hwcu_datapath #(
    .DW(DW), .AW(AW), .RESET_PC(RESET_PC),
    .SAVE_ADDR(SAVE_ADDR), .HANDLER_ADDR(HANDLER_ADDR)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .ctl       (ctl),
    .mem_rdata (mem_rdata),
    .mar       (mar),
    .mbr       (mbr),
    .pc        (pc),
    .ir        (ir),
    .r1        (r1)
  );

  assign mem_addr  = mar;
  assign mem_wdata = mbr;
  assign mem_rd    = ctl.rd;
  assign mem_wr    = ctl.wr;
  assign pc_o      = pc;
  assign ir_o      = ir;
  assign r1_o      = r1;
  assign cyc_o     = cyc;
  assign step_o    = step;

endmodule

// File: rtl/hwcu_chk.sv
module hwcu_chk #(
  parameter int             DW           = 16,
  parameter int             AW           = 12,
  parameter int             STEP_W       = 2,
  parameter logic [AW-1:0]  SAVE_ADDR    = 12'h000,
  parameter logic [AW-1:0]  HANDLER_ADDR = 12'h001
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cyc,
  input logic [STEP_W-1:0] step,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [AW-1:0]     mem_addr,
  input logic [DW-1:0]     mem_wdata,
  input logic [AW-1:0]     pc
);

  // R11
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R11
  rd_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (step == 1));

  // R2
  phase_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cyc) |-> (step == 0));

  // R3
  fetch_pc_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'b00 && step == 1) |=> (pc == $past(pc) + 1'b1));

  // R4
  fetch_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'b00 && step == 2) |=>
      (step == 0 && cyc == ($past(mem_wdata[AW]) ? 2'b01 : 2'b10)));

  // R10
  int_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'b11 && step == 1) |=> (pc == HANDLER_ADDR));

  // R10
  int_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'b11 && mem_wr) |-> (mem_addr == SAVE_ADDR));

endmodule

bind hw_cycle_ctrl hwcu_chk #(
  .DW(DW), .AW(AW), .STEP_W(STEP_W),
  .SAVE_ADDR(SAVE_ADDR), .HANDLER_ADDR(HANDLER_ADDR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .cyc       (cyc_o),
  .step      (step_o),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .pc        (pc_o)
);

// File: tb/hw_cycle_ctrl_tb.sv
module hw_cycle_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] T_LDA = 3'd0, T_ADD = 3'd1, T_AND = 3'd2,
                         T_ISZ = 3'd3, T_BSA = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        irq;
  logic        int_en_set;
  logic [11:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [11:0] pc_o;
  logic [15:0] ir_o, r1_o;
  logic [1:0]  cyc_o, step_o;

  logic [15:0] mem [256];
  logic [11:0] pm;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

  hw_cycle_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq(irq), .int_en_set(int_en_set),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .pc_o(pc_o), .ir_o(ir_o), .r1_o(r1_o), .cyc_o(cyc_o), .step_o(step_o)
  );

  function automatic logic [15:0] mk(input logic [2:0] op, input logic ind,
                                     input logic [11:0] a);
    return {op, ind, a};
  endfunction

  function automatic logic [15:0] pat(input int k);
    case (k)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h8001;
      default: return 16'h5A3C;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Place instr at the modelled PC, then let n cycles elapse from fetch T1.
  task automatic run(input logic [15:0] instr, input int n, input bit en);
    mem[pm[7:0]] = instr;
    int_en_set = en;
    @(negedge clk);
    int_en_set = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic at_fetch(input string req);
    check(req, {cyc_o, step_o}, 4'b0000);
  endtask

  initial begin
    logic [15:0] a, b, v, s;
    rst_n = 1'b0; irq = 1'b0; int_en_set = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pc", pc_o, 12'h010);
    check("R1 r1", r1_o, 0);
    check("R1 cyc/step", {cyc_o, step_o}, 0);
    check("R1 strobes", {mem_rd, mem_wr}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    pm = 12'h010;

    // R6 load sweep
    for (int k = 0; k < 4; k++) begin
      mem[8'h80] = pat(k);
      run(mk(T_LDA, 1'b0, 12'h080), 6, 1'b0);
      pm = pm + 1;
      check("R6 load", r1_o, pat(k));
      check("R3 pc", pc_o, pm);
      at_fetch("R2 lda");
    end

    // R6 add and and sweeps
    for (int op = 0; op < 2; op++) begin
      for (int x = 0; x < 4; x++) begin
        for (int y = 0; y < 4; y++) begin
          a = pat(x); b = pat(y);
          mem[8'h80] = a; mem[8'h81] = b;
          run(mk(T_LDA, 1'b0, 12'h080), 6, 1'b0);
          pm = pm + 1;
          run(mk(op == 0 ? T_ADD : T_AND, 1'b0, 12'h081), 6, 1'b0);
          pm = pm + 1;
          check(op == 0 ? "R6 add" : "R6 and", r1_o,
                op == 0 ? 16'(a + b) : (a & b));
        end
      end
    end
    check("R3 ir", ir_o, mk(T_AND, 1'b0, 12'h081));

    // R7 increment and skip
    for (int k = 0; k < 4; k++) begin
      v = (k == 0) ? 16'hFFFF : (k == 1) ? 16'hFFFE : (k == 2) ? 16'h0000 : 16'h7FFF;
      mem[8'h90] = v;
      run(mk(T_ISZ, 1'b0, 12'h090), 7, 1'b0);
      s = v + 16'd1;
      pm = pm + 1 + ((s == 0) ? 1 : 0);
      check("R7 mem", mem[8'h90], s);
      check("R7 pc", pc_o, pm);
      at_fetch("R2 isz");
    end

    // R8 branch with saved return
    run(mk(T_BSA, 1'b0, 12'h0A0), 6, 1'b0);
    check("R8 saved", mem[8'hA0], {4'h0, pm + 12'd1});
    pm = 12'h0A1;
    check("R8 pc", pc_o, pm);

    // R4 R5 indirect, pointer with opcode bits set
    mem[8'hB0] = 16'hF0C0;
    mem[8'hC0] = 16'h1357;
    mem[pm[7:0]] = mk(T_LDA, 1'b1, 12'h0B0);
    repeat (3) @(negedge clk);
    check("R4 to indirect", {cyc_o, step_o}, 4'b0100);
    repeat (3) @(negedge clk);
    check("R4 to execute", {cyc_o, step_o}, 4'b1000);
    check("R5 ir", ir_o, mk(T_LDA, 1'b1, 12'h0C0));
    repeat (3) @(negedge clk);
    pm = pm + 1;
    check("R5 load", r1_o, 16'h1357);
    at_fetch("R2 ind");

    // R9 unused opcodes
    for (int op = 5; op < 8; op++) begin
      run(mk(3'(op), 1'b0, 12'h080), 4, 1'b0);
      pm = pm + 1;
      check("R9 r1", r1_o, 16'h1357);
      check("R9 pc", pc_o, pm);
      at_fetch("R9 cyc");
    end
    check("R9 mem", mem[8'h80], 16'h5A3C);

    // R12 request ignored while disabled
    irq = 1'b1;
    run(mk(T_LDA, 1'b0, 12'h080), 6, 1'b0);
    pm = pm + 1;
    check("R12 pc", pc_o, pm);
    at_fetch("R12 cyc");

    // R10 interrupt taken after enabling
    run(mk(T_LDA, 1'b0, 12'h080), 9, 1'b1);
    check("R10 saved", mem[8'h00], {4'h0, pm + 12'd1});
    check("R10 pc", pc_o, 12'h001);
    at_fetch("R10 cyc");
    pm = 12'h001;
    // R10 enable cleared on entry
    run(mk(T_LDA, 1'b0, 12'h080), 6, 1'b0);
    check("R10 cleared", pc_o, 12'h002);
    at_fetch("R10 cyc2");
    irq = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule